// File: doc/BRIEF.md
# Staggered Outlet Power-On Sequencer

This block sits between the command path of a switched power distribution unit and the per-outlet relay drivers. Software or a management engine raises turn-on requests for many outlets at once; the sequencer holds them as a pending set and releases the closures one at a time. Each release is gated three ways: the outlet must belong to the stagger group currently being served, a minimum number of timebase ticks must separate it from the previous closure, and the number of outlets still inside their inrush window must be below a configured ceiling. As a result, inrush peaks are spread out in time and do not stack on the upstream breaker.

After every close or open command the block watches the outlet's current-above-threshold flag during a verification window. A close that never shows current is reported as a failed close, and an open that still shows current at the end of the window is reported as a welded switch. A good result is reported through its own pulse, so the block never infers success from silence. Every closure produces an event with the outlet number and the timebase count at the moment of closure, so that a later upstream trip can be matched to the closures that came before it.

Outlets that are locked out or thermally inhibited are dropped from the pending set when their group is served. Such an outlet gets a skip pulse, and it takes no closure slot and no inrush budget. All windows and spacings are counted in ticks of an external 1 ms enable pulse and are set through 16-bit configuration inputs.

Top module: `outlet_stagger_seq`

## Requirements
- R1: After reset all drive lines are 0, busy is 0, the inrush count is 0, the active group is 0 and no event pulse is raised.
- R2: At most one outlet closes per clock cycle. Among the eligible outlets of the active group, the lowest index closes first.
- R3: Outlet i's group number is the field grp_of[i*GW +: GW]. The active group advances to the next number (wrapping to 0) only when no pending outlet belongs to the current group. Outlets of a later group therefore close only after every pending outlet of the earlier group has closed or been skipped.
- R4: After a closure, at least cfg_space ticks must pass before the next closure. With steady ticks, consecutive closure timestamps differ by exactly cfg_space.
- R5: Each closed outlet counts as in inrush for cfg_inrush ticks after its closure. A closure is released only while the in-inrush count is below cfg_max, and later requests wait until the count drops.
- R6: A pending outlet whose inhibit bit is set when its group is served is removed from the pending set. It raises evt_skip for that outlet, its drive stays 0, and it consumes no budget.
- R7: Each closure raises evt_close for one cycle, with evt_id set to the outlet index and evt_time set to the number of ticks seen since reset.
- R8: After a close, if the outlet's current flag is seen within cfg_verify ticks, evt_ok pulses. Otherwise evt_fail pulses and the drive line stays 1.
- R9: An open command clears the outlet's drive on the next clock. When cfg_verify ticks have passed, evt_weld pulses if the current flag is still 1; otherwise evt_ok pulses.
- R10: A request that arrives during a running sequence is added to the pending set without restarting it. A turn-on request for an outlet that is already driven is ignored, and an open request in the same cycle wins over a closure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 1 ms timebase enable pulse |
| req_on | input | N_OUT | Turn-on request pulses, one bit per outlet |
| req_off | input | N_OUT | Open request pulses, one bit per outlet |
| inhibit | input | N_OUT | Lockout or thermal inhibit per outlet |
| grp_of | input | N_OUT*GW | Stagger group of each outlet, GW bits per outlet |
| cur_ok | input | N_OUT | Measured current above threshold per outlet |
| cfg_space | input | TW | Minimum ticks between closures |
| cfg_inrush | input | TW | Inrush window length in ticks |
| cfg_verify | input | TW | Verification window length in ticks |
| cfg_max | input | CNTW | Maximum outlets allowed in inrush at once |
| drive | output | N_OUT | Switch drive per outlet |
| busy | output | 1 | Pending closures remain |
| active_grp | output | GW | Group currently served |
| inrush_cnt | output | CNTW | Outlets currently in their inrush window |
| evt_close | output | 1 | Closure event pulse |
| evt_id | output | IDW | Outlet index of the closure event |
| evt_time | output | TSW | Tick count at the closure |
| evt_ok | output | N_OUT | Verified actuation pulse |
| evt_fail | output | N_OUT | Close without current (stuck off) pulse |
| evt_weld | output | N_OUT | Current after open (stuck on) pulse |
| evt_skip | output | N_OUT | Inhibited outlet skipped pulse |

## Verification
The bench uses the defaults: eight outlets in four groups, 16-bit windows and a 32-bit timestamp. It assigns groups so that index order and group order differ, so the full wrap through all four groups appears within a single bulk request. Eight outlets are enough to reach a budget of two with a third and fourth outlet held back. Small window values (spacing 2, inrush 3, verification 3 ticks) keep every spacing, expiry and verdict within a few dozen cycles. Each combination of command and current level is driven on outlets in different groups.

// File: rtl/stag_pkg.sv
package stag_pkg;
   typedef enum logic [1:0] {
      VF_IDLE  = 2'd0,
      VF_CLOSE = 2'd1,
      VF_OPEN  = 2'd2
   } vf_mode_e;
endpackage

// File: rtl/stag_pick.sv
module stag_pick #(
   parameter int N_OUT     = 8,
   parameter int N_GRP     = 4,
   parameter int GW        = 2,
   parameter int IDW       = 3,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [N_OUT-1:0]    pend,
   input  logic [N_OUT-1:0]    inhibit,
   input  logic [N_OUT*GW-1:0] grp_of,
   input  logic [GW-1:0]       grp,
   output logic                any_elig,
   output logic [IDW-1:0]      pick_id,
   output logic [N_OUT-1:0]    skip_vec,
   output logic                grp_has
);
   logic [N_OUT-1:0] in_g;
   logic [N_OUT-1:0] elig;

   if (N_GRP > (1 << GW)) begin : g_bad_gw
      $error("stag_pick: GW too narrow for N_GRP");
   end

   always_comb begin
      for (int i = 0; i < N_OUT; i++) in_g[i] = (grp_of[i*GW +: GW] == grp);
   end

   assign elig     = pend & ~inhibit & in_g;
   assign skip_vec = pend & inhibit & in_g;
   assign grp_has  = |(pend & in_g);
   assign any_elig = |elig;

   if (LOW_FIRST) begin : g_low
      always_comb begin
         pick_id = '0;
         for (int i = N_OUT-1; i >= 0; i--) if (elig[i]) pick_id = IDW'(i);
      end
   end else begin : g_high
      always_comb begin
         pick_id = '0;
         for (int i = 0; i < N_OUT; i++) if (elig[i]) pick_id = IDW'(i);
      end
   end
endmodule

// File: rtl/stag_pace.sv
module stag_pace #(
   parameter int TW  = 16,
   parameter int TSW = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic           close_fire,
   input  logic [TW-1:0]  cfg_space,
   output logic           space_ok,
   output logic [TSW-1:0] ts
);
   logic [TW-1:0] gap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap <= '0;
         ts  <= '0;
      end else begin
         if (close_fire)            gap <= cfg_space;
         else if (tick && gap != 0) gap <= gap - 1'b1;
         if (tick) ts <= ts + 1'b1;
      end
   end

   assign space_ok = (gap == '0);

   AST_SPACE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      close_fire && cfg_space != '0 |=> !space_ok); // R4
endmodule

// File: rtl/stag_win.sv
module stag_win
   import stag_pkg::*;
#(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          start_close,
   input  logic          start_open,
   input  logic          cur_ok,
   input  logic [TW-1:0] cfg_inrush,
   input  logic [TW-1:0] cfg_verify,
   output logic          in_inrush,
   output logic          ev_ok,
   output logic          ev_fail,
   output logic          ev_weld
);
   logic [TW-1:0] irc;
   logic [TW-1:0] vc;
   vf_mode_e      mode;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irc <= '0;
      end else if (start_close) begin
         irc <= cfg_inrush;
      end else if (start_open) begin
         irc <= '0;
      end else if (tick && irc != '0) begin
         irc <= irc - 1'b1;
      end
   end

   assign in_inrush = (irc != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode    <= VF_IDLE;
         vc      <= '0;
         ev_ok   <= 1'b0;
         ev_fail <= 1'b0;
         ev_weld <= 1'b0;
      end else begin
         ev_ok   <= 1'b0;
         ev_fail <= 1'b0;
         ev_weld <= 1'b0;
         if (start_close) begin
            mode <= VF_CLOSE;
            vc   <= cfg_verify;
         end else if (start_open) begin
            mode <= VF_OPEN;
            vc   <= cfg_verify;
         end else begin
            case (mode)
               VF_CLOSE: begin
                  if (cur_ok) begin
                     ev_ok <= 1'b1;
                     mode  <= VF_IDLE;
                  end else if (vc == '0) begin
                     ev_fail <= 1'b1;
                     mode    <= VF_IDLE;
                  end else if (tick) begin
                     vc <= vc - 1'b1;
                  end
               end
               VF_OPEN: begin
                  if (vc == '0) begin
                     ev_weld <= cur_ok;
                     ev_ok   <= !cur_ok;
                     mode    <= VF_IDLE;
                  end else if (tick) begin
                     vc <= vc - 1'b1;
                  end
               end
               default: mode <= VF_IDLE;
            endcase
         end
      end
   end

   AST_FAIL_NO_CUR: assert property (@(posedge clk) disable iff (!rst_n)
      ev_fail |-> !$past(cur_ok)); // R8
   AST_WELD_HAS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
      ev_weld |-> $past(cur_ok)); // R9
   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_ok, ev_fail, ev_weld})); // R8
endmodule

// File: rtl/outlet_stagger_seq.sv
module outlet_stagger_seq #(
   parameter int N_OUT     = 8,
   parameter int N_GRP     = 4,
   parameter int TW        = 16,
   parameter int TSW       = 32,
   parameter bit LOW_FIRST = 1'b1,
   localparam int GW   = (N_GRP > 1) ? $clog2(N_GRP) : 1,
   localparam int IDW  = (N_OUT > 1) ? $clog2(N_OUT) : 1,
   localparam int CNTW = $clog2(N_OUT + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic [N_OUT-1:0]    req_on,
   input  logic [N_OUT-1:0]    req_off,
   input  logic [N_OUT-1:0]    inhibit,
   input  logic [N_OUT*GW-1:0] grp_of,
   input  logic [N_OUT-1:0]    cur_ok,
   input  logic [TW-1:0]       cfg_space,
   input  logic [TW-1:0]       cfg_inrush,
   input  logic [TW-1:0]       cfg_verify,
   input  logic [CNTW-1:0]     cfg_max,
   output logic [N_OUT-1:0]    drive,
   output logic                busy,
   output logic [GW-1:0]       active_grp,
   output logic [CNTW-1:0]     inrush_cnt,
   output logic                evt_close,
   output logic [IDW-1:0]      evt_id,
   output logic [TSW-1:0]      evt_time,
   output logic [N_OUT-1:0]    evt_ok,
   output logic [N_OUT-1:0]    evt_fail,
   output logic [N_OUT-1:0]    evt_weld,
   output logic [N_OUT-1:0]    evt_skip
);
   if (N_OUT < 2) begin : g_bad_nout
      $error("outlet_stagger_seq: N_OUT must be at least 2");
   end
   if (N_GRP < 1 || N_GRP > N_OUT) begin : g_bad_ngrp
      $error("outlet_stagger_seq: N_GRP out of range");
   end
   if (TW < 2 || TSW < 2) begin : g_bad_tw
      $error("outlet_stagger_seq: counter widths too small");
   end

   logic [N_OUT-1:0] pend;
   logic [GW-1:0]    grp;
   logic             any_elig;
   logic [IDW-1:0]   pick_id;
   logic [N_OUT-1:0] skip_vec;
   logic             grp_has;
   logic             space_ok;
   logic [TSW-1:0]   ts;
   logic             close_fire;
   logic [N_OUT-1:0] close_vec;
   logic [N_OUT-1:0] start_open;
   logic [N_OUT-1:0] in_inr;

   stag_pick #(
      .N_OUT(N_OUT), .N_GRP(N_GRP), .GW(GW), .IDW(IDW), .LOW_FIRST(LOW_FIRST)
   ) u_pick (
      .pend(pend), .inhibit(inhibit), .grp_of(grp_of), .grp(grp),
      .any_elig(any_elig), .pick_id(pick_id), .skip_vec(skip_vec), .grp_has(grp_has)
   );

   stag_pace #(.TW(TW), .TSW(TSW)) u_pace (
      .clk(clk), .rst_n(rst_n), .tick(tick), .close_fire(close_fire),
      .cfg_space(cfg_space), .space_ok(space_ok), .ts(ts)
   );

   assign close_fire = any_elig && space_ok && (inrush_cnt < cfg_max) && !req_off[pick_id];
   assign close_vec  = close_fire ? (N_OUT'(1) << pick_id) : '0;
   assign start_open = req_off & drive;

   for (genvar i = 0; i < N_OUT; i++) begin : g_win
      stag_win #(.TW(TW)) u_win (
         .clk(clk), .rst_n(rst_n), .tick(tick),
         .start_close(close_vec[i]), .start_open(start_open[i]), .cur_ok(cur_ok[i]),
         .cfg_inrush(cfg_inrush), .cfg_verify(cfg_verify),
         .in_inrush(in_inr[i]), .ev_ok(evt_ok[i]), .ev_fail(evt_fail[i]), .ev_weld(evt_weld[i])
      );
   end

   always_comb begin
      inrush_cnt = '0;
      for (int i = 0; i < N_OUT; i++) inrush_cnt = inrush_cnt + CNTW'(in_inr[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend      <= '0;
         drive     <= '0;
         grp       <= '0;
         evt_close <= 1'b0;
         evt_id    <= '0;
         evt_time  <= '0;
         evt_skip  <= '0;
      end else begin
         evt_close <= close_fire;
         evt_skip  <= skip_vec & ~req_off;
         if (close_fire) begin
            evt_id   <= pick_id;
            evt_time <= ts;
         end
         drive <= (drive | close_vec) & ~req_off;
         pend  <= (pend | (req_on & ~drive & ~close_vec)) & ~close_vec & ~skip_vec & ~req_off;
         if (!grp_has && pend != '0)
            grp <= (grp == GW'(N_GRP-1)) ? '0 : grp + 1'b1;
      end
   end

   assign busy       = |pend;
   assign active_grp = grp;

   AST_ONE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drive & ~$past(drive))); // R2
   AST_GRP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (grp != $past(grp)) |-> !$past(grp_has)); // R3
   AST_NO_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
      close_fire && cfg_space != '0 |=> !close_fire); // R4
   AST_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
      close_fire |-> inrush_cnt < cfg_max); // R5
   AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_off != '0) |=> ((drive & $past(req_off)) == '0)); // R10
endmodule

// File: tb/sim_outlet_stagger_seq.sv
module sim_outlet_stagger_seq;
   localparam int N = 8;
   localparam int GWB = 2;
   localparam int CW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic [N-1:0] req_on = '0, req_off = '0, inhibit = '0, cur_ok = '0;
   logic [N*GWB-1:0] grp_of;
   logic [15:0] cfg_space = '0, cfg_inrush = '0, cfg_verify = '0;
   logic [CW-1:0] cfg_max = '0;
   logic [N-1:0] drive, evt_ok, evt_fail, evt_weld, evt_skip;
   logic busy, evt_close;
   logic [GWB-1:0] active_grp;
   logic [CW-1:0] inrush_cnt;
   logic [2:0] evt_id;
   logic [31:0] evt_time;

   always #5 clk = ~clk;

   outlet_stagger_seq u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .req_on(req_on), .req_off(req_off),
      .inhibit(inhibit), .grp_of(grp_of), .cur_ok(cur_ok), .cfg_space(cfg_space),
      .cfg_inrush(cfg_inrush), .cfg_verify(cfg_verify), .cfg_max(cfg_max),
      .drive(drive), .busy(busy), .active_grp(active_grp), .inrush_cnt(inrush_cnt),
      .evt_close(evt_close), .evt_id(evt_id), .evt_time(evt_time), .evt_ok(evt_ok),
      .evt_fail(evt_fail), .evt_weld(evt_weld), .evt_skip(evt_skip)
   );

   int checks = 0, errors = 0;
   int n_ev = 0;
   int ev_id [0:15];
   int ev_ts [0:15];
   int ok_c [0:N-1], fail_c [0:N-1], weld_c [0:N-1], skip_c [0:N-1];

   // group of outlet i: 2,0,1,0,2,1,3,0
   localparam int GRP [0:N-1] = '{2, 0, 1, 0, 2, 1, 3, 0};
   // vector: outlet[6:4] op[3] (0 close, 1 open) cur[2] verdict[1:0] (0 ok, 1 fail, 2 weld)
   localparam logic [6:0] VT [0:7] = '{
      {3'd2, 1'b0, 1'b1, 2'd0}, {3'd2, 1'b1, 1'b0, 2'd0},
      {3'd5, 1'b0, 1'b0, 2'd1}, {3'd5, 1'b1, 1'b1, 2'd2},
      {3'd6, 1'b0, 1'b1, 2'd0}, {3'd6, 1'b1, 1'b1, 2'd2},
      {3'd0, 1'b0, 1'b0, 2'd1}, {3'd0, 1'b1, 1'b0, 2'd0}
   };

   always @(negedge clk) begin
      if (!rst_n) begin
         n_ev = 0;
         for (int i = 0; i < N; i++) begin
            ok_c[i] = 0; fail_c[i] = 0; weld_c[i] = 0; skip_c[i] = 0;
         end
      end else begin
         if (evt_close && n_ev < 16) begin
            ev_id[n_ev] = int'(evt_id);
            ev_ts[n_ev] = int'(evt_time);
            n_ev++;
         end
         for (int i = 0; i < N; i++) begin
            ok_c[i] += int'(evt_ok[i]);
            fail_c[i] += int'(evt_fail[i]);
            weld_c[i] += int'(evt_weld[i]);
            skip_c[i] += int'(evt_skip[i]);
         end
      end
   end

   task automatic chk(input bit cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic ticks(input int k);
      repeat (k) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
         idle(2);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; req_on = '0; req_off = '0; inhibit = '0; cur_ok = '0; tick = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
   endtask

   task automatic pulse_on(input logic [N-1:0] v);
      req_on = v; @(negedge clk); req_on = '0;
   endtask

   task automatic pulse_off(input logic [N-1:0] v);
      req_off = v; @(negedge clk); req_off = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) grp_of[i*GWB +: GWB] = GWB'(GRP[i]);

      // R1: reset state
      do_reset();
      chk(drive == '0, "R1 drive", int'(drive), 0);
      chk(busy == 1'b0, "R1 busy", int'(busy), 0);
      chk(inrush_cnt == '0, "R1 inrush_cnt", int'(inrush_cnt), 0);
      chk(active_grp == '0, "R1 active_grp", int'(active_grp), 0);
      chk(n_ev == 0 && evt_ok == '0, "R1 events", n_ev, 0);

      // R2 R3: bulk request, ascending within group, group by group
      cfg_space = 16'd0; cfg_inrush = 16'd0; cfg_verify = 16'd3; cfg_max = 4'd8;
      pulse_on(8'hFF);
      idle(40);
      chk(n_ev == 8, "R2 close count", n_ev, 8);
      begin
         int exp_order [0:7] = '{1, 3, 7, 2, 5, 0, 4, 6};
         for (int k = 0; k < 8; k++)
            chk(ev_id[k] == exp_order[k], "R3 closure order", ev_id[k], exp_order[k]);
      end
      chk(drive == 8'hFF, "R2 all driven", int'(drive), 255);

      // R4 R7 R10: spacing, timestamps, mid-sequence append, redundant on ignored
      do_reset();
      cfg_space = 16'd2; cfg_inrush = 16'd0; cfg_max = 4'd8;
      pulse_on(8'b0000_1010);
      while (n_ev < 1) idle(1);
      pulse_on(8'b1000_0010);
      ticks(6);
      idle(10);
      chk(n_ev == 3, "R10 appended, no repeat", n_ev, 3);
      chk(ev_id[0] == 1 && ev_id[1] == 3 && ev_id[2] == 7, "R10 order 1,3,7", ev_id[2], 7);
      chk(ev_ts[0] == 0, "R7 first timestamp", ev_ts[0], 0);
      chk(ev_ts[1] - ev_ts[0] == 2, "R4 spacing first gap", ev_ts[1] - ev_ts[0], 2);
      chk(ev_ts[2] - ev_ts[1] == 2, "R4 spacing second gap", ev_ts[2] - ev_ts[1], 2);

      // R5: inrush budget
      do_reset();
      cfg_space = 16'd0; cfg_inrush = 16'd3; cfg_max = 4'd2;
      pulse_on(8'b1000_1110);
      idle(12);
      chk(n_ev == 2, "R5 held at budget", n_ev, 2);
      chk(inrush_cnt == 4'd2, "R5 inrush count", int'(inrush_cnt), 2);
      chk(busy == 1'b1, "R5 still pending", int'(busy), 1);
      ticks(3);
      idle(10);
      chk(n_ev == 4, "R5 released after window", n_ev, 4);
      chk(ev_id[2] == 7 && ev_id[3] == 2, "R5 released order", ev_id[3], 2);
      chk(inrush_cnt == 4'd2, "R5 new inrush count", int'(inrush_cnt), 2);

      // R6: inhibited outlet skipped, consumes no budget
      do_reset();
      cfg_space = 16'd0; cfg_inrush = 16'd5; cfg_max = 4'd1;
      inhibit = 8'b0000_1000;
      pulse_on(8'b1000_1000);
      idle(10);
      chk(skip_c[3] == 1, "R6 skip pulse", skip_c[3], 1);
      chk(drive[3] == 1'b0, "R6 inhibited not driven", int'(drive[3]), 0);
      chk(n_ev == 1 && ev_id[0] == 7, "R6 neighbour closes", ev_id[0], 7);
      chk(busy == 1'b0, "R6 pending cleared", int'(busy), 0);

      // R10: open wins over closure in the same cycle
      do_reset();
      cfg_space = 16'd0; cfg_inrush = 16'd0; cfg_max = 4'd8;
      req_on = 8'b0000_0010; req_off = 8'b0000_0010;
      @(negedge clk);
      req_on = '0; req_off = '0;
      idle(6);
      chk(drive[1] == 1'b0 && n_ev == 0, "R10 off wins", int'(drive[1]), 0);

      // R8 R9: verification verdicts, table driven
      do_reset();
      cfg_space = 16'd0; cfg_inrush = 16'd0; cfg_verify = 16'd3; cfg_max = 4'd8;
      for (int k = 0; k < 8; k++) begin
         int o, d_ok, d_fail, d_weld, ok0, fail0, weld0;
         o = int'(VT[k][6:4]);
         ok0 = ok_c[o]; fail0 = fail_c[o]; weld0 = weld_c[o];
         cur_ok[o] = VT[k][2];
         if (VT[k][3] == 1'b0) pulse_on(N'(1) << o);
         else pulse_off(N'(1) << o);
         ticks(6);
         d_ok = ok_c[o] - ok0; d_fail = fail_c[o] - fail0; d_weld = weld_c[o] - weld0;
         case (VT[k][1:0])
            2'd0: chk(d_ok == 1 && d_fail == 0 && d_weld == 0, "R8 R9 verdict ok", d_ok, 1);
            2'd1: chk(d_fail == 1 && d_ok == 0, "R8 verdict fail", d_fail, 1);
            default: chk(d_weld == 1 && d_ok == 0, "R9 verdict weld", d_weld, 1);
         endcase
         if (VT[k][3] == 1'b0)
            chk(drive[o] == 1'b1, "R8 drive held after close", int'(drive[o]), 1);
         else
            chk(drive[o] == 1'b0, "R9 drive cleared after open", int'(drive[o]), 0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule